// File: doc/BRIEF.md
# Procedure Return Sequencer

This block carries out the return half of a procedure call against a stack of 16-bit words that lives in byte-wide memory. When it is told to start, it pops the saved return offset into its instruction pointer. For a far return it also pops a code segment value. After the pops it can release further stack space by adding a caller-supplied amount to the stack pointer. It then raises a one-cycle completion pulse.

The block reads memory through a synchronous byte read port. Each read returns its byte one cycle after the address is presented. Words are stored little-endian: the low byte is at the lower address. The stack pointer can be preset through a simple write strobe while the block is idle. The instruction pointer and code segment are only ever written by the pops. No condition flags exist in or are touched by the block.

Top module: `ret_seq`

## Requirements
- R1: After a synchronous active-high reset, the instruction pointer, code segment and stack pointer read 0, and `busy` and `done` are 0.
- R2: When idle, a high `sp_wr` loads `sp_wdata` into the stack pointer at the next edge. While `busy` is high, `sp_wr` has no effect.
- R3: A return loads the instruction pointer with the byte at SP as bits 7:0 and the byte at SP+1 as bits 15:8, using the SP in force at the start. That pop then adds 2 to SP.
- R4: When `far_sel` is 1 at the start, the next word is popped into the code segment after the instruction-pointer pop. Its low byte is at the updated SP and its high byte at the updated SP+1. SP then gains another 2.
- R5: When `far_sel` is 0 at the start, the code segment keeps its value and exactly two bytes are read.
- R6: After all pops, the 16-bit `pop_adj` captured at start is added to SP. All SP arithmetic wraps modulo 2^16.
- R7: Byte addresses wrap modulo 2^16, so the word at SP=0xFFFF takes its high byte from address 0x0000.
- R8: `busy` rises on the edge that accepts `start` and stays high until `done` rises. `done` is high for exactly one cycle. `done` follows the accepting edge by 4 edges for a near return and by 7 for a far return.
- R9: A `start` seen while `busy` is high is ignored: no second return runs and the values of the running one are not changed.
- R10: `mem_rd` is high only while `busy` is high. A read is issued once per cycle, and the data is taken from `mem_rdata` on the cycle after its address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a return (accepted only when idle) |
| far_sel | input | 1 | 1: also pop code segment; 0: pop offset only |
| pop_adj | input | 16 | Amount added to SP after the pops |
| sp_wr | input | 1 | Stack pointer preset strobe (idle only) |
| sp_wdata | input | 16 | Stack pointer preset value |
| mem_rd | output | 1 | Byte read request |
| mem_addr | output | 16 | Byte read address |
| mem_rdata | input | 8 | Read data, valid one cycle after the request |
| ip_q | output | 16 | Instruction pointer |
| cs_q | output | 16 | Code segment |
| sp_q | output | 16 | Stack pointer |
| busy | output | 1 | Return in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded assertions check, on every cycle, the rules that hold step by step. They cover the one-cycle `done` pulse and that `done` and `busy` never overlap. They check that reads occur only while busy, that the instruction pointer never moves while idle, and that the code segment stays fixed during a near return. They also check that SP changes only on a pop, the adjustment step or an idle preset. Only the bench scenarios can show the actual popped values and byte order, the wrap across 0xFFFF, the adjustment sum, the exact latency, and that a start during a run is dropped.

// File: rtl/ret_seq.sv
module ret_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         far_sel,
  input  logic [W-1:0] pop_adj,
  input  logic         sp_wr,
  input  logic [W-1:0] sp_wdata,
  output logic         mem_rd,
  output logic [W-1:0] mem_addr,
  input  logic [7:0]   mem_rdata,
  output logic [W-1:0] ip_q,
  output logic [W-1:0] cs_q,
  output logic [W-1:0] sp_q,
  output logic         busy,
  output logic         done
);

  typedef enum logic [2:0] {
    S_IDLE, S_IP0, S_IP1, S_IP2, S_CS0, S_CS1, S_CS2, S_ADJ
  } st_t;

  st_t          st;
  logic         far_q;
  logic [W-1:0] adj_q;

  assign busy     = (st != S_IDLE);
  assign mem_rd   = (st == S_IP0) || (st == S_IP1) || (st == S_CS0) || (st == S_CS1);
  assign mem_addr = ((st == S_IP1) || (st == S_CS1)) ? sp_q + W'(1) : sp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      far_q <= 1'b0;
      adj_q <= '0;
      ip_q  <= '0;
      cs_q  <= '0;
      sp_q  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (sp_wr) sp_q <= sp_wdata;
          if (start) begin
            far_q <= far_sel;
            adj_q <= pop_adj;
            st    <= S_IP0;
          end
        end
        S_IP0: st <= S_IP1;
        S_IP1: begin
          ip_q[7:0] <= mem_rdata;
          st        <= S_IP2;
        end
        S_IP2: begin
          ip_q[15:8] <= mem_rdata;
          sp_q       <= sp_q + W'(2);
          st         <= far_q ? S_CS0 : S_ADJ;
        end
        S_CS0: st <= S_CS1;
        S_CS1: begin
          cs_q[7:0] <= mem_rdata;
          st        <= S_CS2;
        end
        S_CS2: begin
          cs_q[15:8] <= mem_rdata;
          sp_q       <= sp_q + W'(2);
          st         <= S_ADJ;
        end
        S_ADJ: begin
          sp_q <= sp_q + adj_q;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_read_in_run_R10: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> busy);

  assert_ip_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(ip_q));

  assert_cs_hold_near_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && !far_q) |=> $stable(cs_q));

  assert_sp_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && st != S_IP2 && st != S_CS2 && st != S_ADJ) |=> $stable(sp_q));

  assert_far_latched_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && $past(busy)) |-> $stable(far_q));

endmodule

// File: tb/ret_seq_tb.sv
module ret_seq_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, far_sel = 1'b0, sp_wr = 1'b0;
  logic [15:0] pop_adj = '0, sp_wdata = '0;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic [15:0] ip_q, cs_q, sp_q;
  logic        busy, done;

  int checks = 0, errors = 0;
  int rd_count = 0;
  logic wd_fired = 1'b0;

  always #5 clk = ~clk;

  ret_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .far_sel(far_sel), .pop_adj(pop_adj),
    .sp_wr(sp_wr), .sp_wdata(sp_wdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .ip_q(ip_q), .cs_q(cs_q), .sp_q(sp_q),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  function automatic logic [15:0] word_at(input logic [15:0] a);
    return {byte_at(a + 16'd1), byte_at(a)};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= byte_at(mem_addr);
      rd_count  <= rd_count + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic preset_sp(input logic [15:0] v);
    @(negedge clk); sp_wr = 1'b1; sp_wdata = v;
    @(negedge clk); sp_wr = 1'b0;
  endtask

  task automatic run_ret(input logic f, input logic [15:0] adj,
                         input int inj_at, output int lat);
    int cnt = 0;
    rd_count = 0;
    start = 1'b1; far_sel = f; pop_adj = adj;
    @(negedge clk); start = 1'b0; far_sel = 1'b0; pop_adj = 16'hDEAD;
    check("R8 busy after start", busy, 1);
    while (!done && cnt < 50) begin
      if (cnt == inj_at) begin start = 1'b1; far_sel = 1'b1; end
      @(negedge clk);
      start = 1'b0; far_sel = 1'b0;
      cnt++;
    end
    lat = cnt;
  endtask

  typedef struct packed { logic [15:0] sp; logic far; logic [15:0] adj; } vec_t;
  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{16'h1000, 1'b0, 16'h0000},
    '{16'h2000, 1'b1, 16'h0000},
    '{16'h3456, 1'b0, 16'h0004},
    '{16'h7FF0, 1'b1, 16'h0010},
    '{16'hFFFF, 1'b0, 16'h0000},
    '{16'hFFFE, 1'b1, 16'hFFFF}
  };

  initial begin
    #500000;
    wd_fired = 1'b1;
  end

  initial begin
    int lat;
    logic [15:0] cs_exp;
    logic [15:0] ip_exp, sp_exp;

    // R1 reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ip", ip_q, 0);
    check("R1 cs", cs_q, 0);
    check("R1 sp", sp_q, 0);
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);

    // R2 preset
    preset_sp(16'h0ABC);
    check("R2 sp preset", sp_q, 16'h0ABC);

    cs_exp = 16'h0000;
    for (int i = 0; i < NV; i++) begin
      preset_sp(VEC[i].sp);
      ip_exp = word_at(VEC[i].sp);
      if (VEC[i].far) begin
        cs_exp = word_at(VEC[i].sp + 16'd2);
        sp_exp = VEC[i].sp + 16'd4 + VEC[i].adj;
      end else begin
        sp_exp = VEC[i].sp + 16'd2 + VEC[i].adj;
      end
      run_ret(VEC[i].far, VEC[i].adj, -1, lat);
      check("R3/R7 ip", ip_q, ip_exp);
      check(VEC[i].far ? "R4 cs" : "R5 cs kept", cs_q, cs_exp);
      check("R6 sp", sp_q, sp_exp);
      check("R8 latency", lat, VEC[i].far ? 4 + 3 : 4);
      check("R10 read count", rd_count, VEC[i].far ? 4 : 2);
      check("R8 busy at done", busy, 0);
      @(negedge clk);
      check("R8 done one cycle", done, 0);
    end

    // R9: start during a near run is ignored
    preset_sp(16'h4000);
    run_ret(1'b0, 16'h0002, 1, lat);
    check("R9 latency unchanged", lat, 4);
    check("R9 ip", ip_q, word_at(16'h4000));
    check("R9 cs kept", cs_q, cs_exp);
    check("R9 sp", sp_q, 16'h4004);
    repeat (4) begin
      @(negedge clk);
      check("R9 no second run", {busy, done}, 2'b00);
    end

    // R2: sp write ignored while busy
    preset_sp(16'h5000);
    start = 1'b1; far_sel = 1'b0; pop_adj = 16'h0000;
    @(negedge clk); start = 1'b0;
    sp_wr = 1'b1; sp_wdata = 16'h1234;
    @(negedge clk); sp_wr = 1'b0;
    while (!done && !wd_fired) @(negedge clk);
    check("R2 write ignored busy", sp_q, 16'h5002);
    check("R2 ip", ip_q, word_at(16'h5000));

    // R1: reset mid-run
    preset_sp(16'h6000);
    start = 1'b1; far_sel = 1'b1;
    @(negedge clk); start = 1'b0; far_sel = 1'b0;
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset sp", sp_q, 0);
    check("R1 reset busy", busy, 0);
    check("R1 reset ip", ip_q, 0);

    if (wd_fired) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (wd_fired);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule